// File: doc/BRIEF.md
# Debug memory access sequencer

This block turns a single memory-access command into the ordered series of debug scans that a halted target CPU needs. It sits above a serial shift engine: for every step it presents a request carrying the scan type (instruction or data) and a 16-bit value, waits for the engine's acknowledge, and takes the value shifted back out. Between scans it drives the target's test-clock level directly.

A host starts one operation with a single-cycle start pulse. Three operations are available. The first tests the security fuse. The second reads one byte or one word. The third writes one byte or one word. A read or a write always runs three phases in a row: a halt that freezes the CPU on a jump-to-self instruction, then the access, then a release. When the operation ends, the block raises `done` for one cycle and shows the read data and two status flags. The flags stay valid until the next operation starts.

The instruction codes sent in instruction scans are 8 bits wide and travel in the low byte of the scan value. Their values are:

| Code | Use |
|------|-----|
| 0x13 | control-word write |
| 0x14 | control capture |
| 0x83 | address write |
| 0x41 | data write |
| 0x85 | data-to-address |
| 0x84 | address capture |

Top module: `dbg_mem_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `fail`, `fuse_blown`, `scan_req` and `rdata` are all 0, and `tclk` is 1.
- R2: Op code 0 (fuse check) makes up to 3 attempts. Each attempt is a control-capture instruction scan (0x14) followed by a data scan of 0xAAAA. A returned 0x5555 sets `fuse_blown` and ends the operation at once. Three attempts with any other reply end it with `fuse_blown` at 0.
- R3: Halt starts with one control-capture scan. It then makes up to 50 data scans of 0x0000, which stop as soon as bit 7 of the reply is 1. Between two such scans `tclk` goes low and then high. If the 50th scan is still clear, `fail` is set and the operation ends with no further scan or `tclk` change.
- R4: After a successful poll, halt continues in this order:
  - instruction 0x13, then data 0x2401;
  - instruction 0x41, then data 0x3FFF;
  - `tclk` high, then low;
  - instruction 0x13, then data 0x2409;
  - `tclk` left high.
- R5: Op code 1 (read) runs the halt, then this access:
  - `tclk` low;
  - instruction 0x13, then the read control word (0x2409 for a word, 0x2419 when `op_byte` is 1);
  - instruction 0x83, then the address;
  - instruction 0x85;
  - `tclk` high, then low;
  - a data scan of 0x0000 whose reply becomes `rdata`;
  - `tclk` high.
- R6: When `op_byte` is 1, a read returns only the low 8 bits of the captured value, zero-extended.
- R7: Op code 2 (write) runs the halt, then the same address steps as a read, using the control word 0x2408 for a word or 0x2418 for a byte. It then sends a data scan of `op_wdata` and raises `tclk`.
- R8: Every read or write ends with a release: `tclk` low, instruction 0x13, data 0x2401, instruction 0x84, and `tclk` high.
- R9: `done` is high for exactly one cycle per operation, and `busy` is low while it is high. Op code 3 is reserved: it completes at once with no scan.
- R10: `fail` and `fuse_blown` keep their value while the block is idle. Both clear when the next operation is accepted.
- R11: A start pulse that arrives while `busy` is 1 is ignored. It changes neither the running sequence nor its result.
- R12: Once `scan_req` has been raised, the block holds it, `scan_kind` and `scan_val` steady until it sees `scan_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse that starts an operation when idle |
| op_code | input | 2 | 0 fuse check, 1 read, 2 write, 3 reserved |
| op_byte | input | 1 | 1 selects a byte access, 0 a word access |
| op_addr | input | 16 | Target address for read or write |
| op_wdata | input | 16 | Data to write |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdata | output | 16 | Result of the last read |
| fail | output | 1 | Halt poll timed out; the operation was aborted |
| fuse_blown | output | 1 | Fuse check saw the blown pattern |
| tclk | output | 1 | Test-clock level driven to the target |
| scan_req | output | 1 | Scan request to the shift engine |
| scan_kind | output | 1 | 0 instruction scan, 1 data scan |
| scan_val | output | 16 | Value to shift in |
| scan_ack | input | 1 | One-cycle acknowledge from the shift engine |
| scan_ret | input | 16 | Value shifted out, valid with `scan_ack` |

## Verification
The assertions assume the shift engine acknowledges only a request that is pending, with a one-cycle `scan_ack` pulse. They also assume the host pulses `op_start` for one cycle and never in the cycle where `done` is high. The bench's engine model raises `scan_ack` only while `scan_req` is high, and it drops `scan_ack` after one cycle. It can hold back the acknowledge by a configurable number of cycles, which exercises the stability rule. Every start pulse is driven at least two cycles after `done`. The one exception is the R11 test, which pulses `op_start` while `busy` is high.

// File: rtl/dbg_seq_pkg.sv
// Shared types and constants for the debug memory access sequencer.
// Assumes a 16-bit target data path and 8-bit instruction codes.
package dbg_seq_pkg;

    localparam int DATA_W = 16;
    localparam int PC_W   = 5;

    // operation codes seen at the host port
    typedef enum logic [1:0] {
        OPC_FUSE  = 2'd0,
        OPC_READ  = 2'd1,
        OPC_WRITE = 2'd2,
        OPC_RSVD  = 2'd3
    } opc_e;

    // what one program step does
    typedef enum logic [1:0] {
        STK_IR,
        STK_DR,
        STK_TCLK_LO,
        STK_TCLK_HI
    } stk_e;

    // how the reply of a data scan is judged
    typedef enum logic [1:0] {
        CHK_NONE,
        CHK_FUSE,
        CHK_FETCH,
        CHK_GRAB
    } chk_e;

    typedef struct packed {
        stk_e              kind;
        chk_e              chk;
        logic              last;
        logic [DATA_W-1:0] val;
    } step_t;

    // instruction codes (low byte of an instruction scan)
    localparam logic [DATA_W-1:0] INS_CTRL_WR  = 16'h0013;
    localparam logic [DATA_W-1:0] INS_CTRL_CAP = 16'h0014;
    localparam logic [DATA_W-1:0] INS_ADDR_WR  = 16'h0083;
    localparam logic [DATA_W-1:0] INS_DATA_WR  = 16'h0041;
    localparam logic [DATA_W-1:0] INS_DATA2ADR = 16'h0085;
    localparam logic [DATA_W-1:0] INS_ADDR_CAP = 16'h0084;

    // control words and fixed data values
    localparam logic [DATA_W-1:0] CW_IDLE    = 16'h2401;
    localparam logic [DATA_W-1:0] CW_RD_WORD = 16'h2409;
    localparam logic [DATA_W-1:0] CW_RD_BYTE = 16'h2419;
    localparam logic [DATA_W-1:0] CW_WR_WORD = 16'h2408;
    localparam logic [DATA_W-1:0] CW_WR_BYTE = 16'h2418;
    localparam logic [DATA_W-1:0] JMP_SELF   = 16'h3FFF;
    localparam logic [DATA_W-1:0] FUSE_PROBE = 16'hAAAA;
    localparam logic [DATA_W-1:0] FUSE_GONE  = 16'h5555;

    // program layout; the jumps between phases depend on these
    localparam logic [PC_W-1:0] PC_FUSE   = 5'd0;
    localparam logic [PC_W-1:0] PC_HALT   = 5'd2;
    localparam logic [PC_W-1:0] PC_POLL   = 5'd3;
    localparam logic [PC_W-1:0] PC_PULSE  = 5'd4;
    localparam logic [PC_W-1:0] PC_FROZEN = 5'd6;
    localparam logic [PC_W-1:0] PC_SPLIT  = 5'd20;
    localparam logic [PC_W-1:0] PC_RD     = 5'd21;
    localparam logic [PC_W-1:0] PC_RD_END = 5'd24;
    localparam logic [PC_W-1:0] PC_WR     = 5'd25;
    localparam logic [PC_W-1:0] PC_REL    = 5'd27;
    localparam logic [PC_W-1:0] PC_END    = 5'd31;

    function automatic step_t mk(stk_e k, logic [DATA_W-1:0] v, chk_e c);
        step_t s;
        s.kind = k;
        s.chk  = c;
        s.last = 1'b0;
        s.val  = v;
        return s;
    endfunction

endpackage

// File: rtl/dbg_seq_rom.sv
// Step table: decodes the program counter into one scan or TCLK action,
// plus the default successor. Purely combinational; assumes the latched
// operation fields are stable while a sequence runs.
module dbg_seq_rom
    import dbg_seq_pkg::*;
(
    input  logic [PC_W-1:0]   pc,
    input  logic              is_write,
    input  logic              is_byte,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output step_t             step,
    output logic [PC_W-1:0]   pc_next
);

    logic [DATA_W-1:0] ctrl_word;

    // select the access control word from direction and size
    always_comb begin
        if (is_write) ctrl_word = is_byte ? CW_WR_BYTE : CW_WR_WORD;
        else          ctrl_word = is_byte ? CW_RD_BYTE : CW_RD_WORD;
    end

    // map each program address to its action and successor
    always_comb begin
        step    = mk(STK_TCLK_HI, '0, CHK_NONE);
        pc_next = pc + 1'b1;
        case (pc)
            // fuse check
            5'd0:  step = mk(STK_IR, INS_CTRL_CAP, CHK_NONE);
            5'd1:  step = mk(STK_DR, FUSE_PROBE, CHK_FUSE);
            // halt: wait for instruction fetch
            5'd2:  step = mk(STK_IR, INS_CTRL_CAP, CHK_NONE);
            5'd3:  step = mk(STK_DR, '0, CHK_FETCH);
            5'd4:  step = mk(STK_TCLK_LO, '0, CHK_NONE);
            5'd5:  begin
                step    = mk(STK_TCLK_HI, '0, CHK_NONE);
                pc_next = PC_POLL;
            end
            // halt: freeze on jump-to-self
            5'd6:  step = mk(STK_IR, INS_CTRL_WR, CHK_NONE);
            5'd7:  step = mk(STK_DR, CW_IDLE, CHK_NONE);
            5'd8:  step = mk(STK_IR, INS_DATA_WR, CHK_NONE);
            5'd9:  step = mk(STK_DR, JMP_SELF, CHK_NONE);
            5'd10: step = mk(STK_TCLK_HI, '0, CHK_NONE);
            5'd11: step = mk(STK_TCLK_LO, '0, CHK_NONE);
            5'd12: step = mk(STK_IR, INS_CTRL_WR, CHK_NONE);
            5'd13: step = mk(STK_DR, CW_RD_WORD, CHK_NONE);
            5'd14: step = mk(STK_TCLK_HI, '0, CHK_NONE);
            // access: common address phase
            5'd15: step = mk(STK_TCLK_LO, '0, CHK_NONE);
            5'd16: step = mk(STK_IR, INS_CTRL_WR, CHK_NONE);
            5'd17: step = mk(STK_DR, ctrl_word, CHK_NONE);
            5'd18: step = mk(STK_IR, INS_ADDR_WR, CHK_NONE);
            5'd19: step = mk(STK_DR, addr, CHK_NONE);
            5'd20: begin
                step    = mk(STK_IR, INS_DATA2ADR, CHK_NONE);
                pc_next = is_write ? PC_WR : PC_RD;
            end
            // access: read tail
            5'd21: step = mk(STK_TCLK_HI, '0, CHK_NONE);
            5'd22: step = mk(STK_TCLK_LO, '0, CHK_NONE);
            5'd23: step = mk(STK_DR, '0, CHK_GRAB);
            5'd24: begin
                step    = mk(STK_TCLK_HI, '0, CHK_NONE);
                pc_next = PC_REL;
            end
            // access: write tail
            5'd25: step = mk(STK_DR, wdata, CHK_NONE);
            5'd26: step = mk(STK_TCLK_HI, '0, CHK_NONE);
            // release
            5'd27: step = mk(STK_TCLK_LO, '0, CHK_NONE);
            5'd28: step = mk(STK_IR, INS_CTRL_WR, CHK_NONE);
            5'd29: step = mk(STK_DR, CW_IDLE, CHK_NONE);
            5'd30: step = mk(STK_IR, INS_ADDR_CAP, CHK_NONE);
            default: begin
                step      = mk(STK_TCLK_HI, '0, CHK_NONE);
                step.last = 1'b1;
                pc_next   = PC_END;
            end
        endcase
    end

endmodule

// File: rtl/dbg_scan_port.sv
// Request/acknowledge port to the shift engine. A start pulse latches the
// scan type and value and holds the request until the engine acknowledges;
// the reply is then registered and flagged for one cycle.
// Assumes start only arrives while no request is pending.
module dbg_scan_port #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          kind_in,
    input  logic [DW-1:0] val_in,
    output logic          req,
    output logic          kind,
    output logic [DW-1:0] val,
    input  logic          ack,
    input  logic [DW-1:0] ret,
    output logic          fin,
    output logic [DW-1:0] fin_data
);

    // hold the request until it is acknowledged, then return the reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= 1'b0;
            kind     <= 1'b0;
            val      <= '0;
            fin      <= 1'b0;
            fin_data <= '0;
        end else begin
            fin <= 1'b0;
            if (start && !req) begin
                req  <= 1'b1;
                kind <= kind_in;
                val  <= val_in;
            end else if (req && ack) begin
                req      <= 1'b0;
                fin      <= 1'b1;
                fin_data <= ret;
            end
        end
    end

endmodule

// File: rtl/dbg_retry_ctr.sv
// Attempt counter for a bounded poll. It flags the last permitted attempt;
// clear wins over increment. Assumes LIMIT >= 1.
module dbg_retry_ctr #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // count failed attempts of the current operation
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/dbg_mem_seq.sv
// Debug memory access sequencer (top). It walks the step table for one
// host operation, issues scans through the scan port, drives TCLK, judges
// the fuse and fetch polls, and reports done, read data and status.
// Assumes op_start is a one-cycle pulse and the engine acknowledges once
// per request.
module dbg_mem_seq
    import dbg_seq_pkg::*;
#(
    parameter int FUSE_TRIES  = 3,
    parameter int FETCH_TRIES = 50,
    parameter int FETCH_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_code,
    input  logic              op_byte,
    input  logic [DATA_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic              fuse_blown,
    output logic              tclk,
    output logic              scan_req,
    output logic              scan_kind,
    output logic [DATA_W-1:0] scan_val,
    input  logic              scan_ack,
    input  logic [DATA_W-1:0] scan_ret
);

    typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_WAIT} st_e;

    st_e               st;
    logic [PC_W-1:0]   pc;
    opc_e              opc_q;
    logic              byte_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q;

    step_t             step;
    logic [PC_W-1:0]   pc_next;
    logic              port_start;
    logic              fin;
    logic [DATA_W-1:0] fin_data;
    logic              accept;
    logic              fuse_last;
    logic              fetch_last;
    logic              fuse_inc;
    logic              fetch_inc;
    logic              is_scan;

    dbg_seq_rom u_rom (
        .pc       (pc),
        .is_write (opc_q == OPC_WRITE),
        .is_byte  (byte_q),
        .addr     (addr_q),
        .wdata    (wd_q),
        .step     (step),
        .pc_next  (pc_next)
    );

    dbg_scan_port #(.DW(DATA_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (port_start),
        .kind_in  (step.kind == STK_DR),
        .val_in   (step.val),
        .req      (scan_req),
        .kind     (scan_kind),
        .val      (scan_val),
        .ack      (scan_ack),
        .ret      (scan_ret),
        .fin      (fin),
        .fin_data (fin_data)
    );

    dbg_retry_ctr #(.LIMIT(FUSE_TRIES)) u_fuse_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (fuse_inc),
        .last  (fuse_last)
    );

    dbg_retry_ctr #(.LIMIT(FETCH_TRIES)) u_fetch_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (fetch_inc),
        .last  (fetch_last)
    );

    // decode handshake and retry events of the current cycle
    always_comb begin
        accept     = (st == ST_IDLE) && op_start;
        is_scan    = (step.kind == STK_IR) || (step.kind == STK_DR);
        port_start = (st == ST_STEP) && is_scan;
        fuse_inc   = (st == ST_WAIT) && fin && (step.chk == CHK_FUSE)
                     && (fin_data != FUSE_GONE) && !fuse_last;
        fetch_inc  = (st == ST_WAIT) && fin && (step.chk == CHK_FETCH)
                     && !fin_data[FETCH_BIT] && !fetch_last;
    end

    // sequence control: accept, step, judge replies, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            pc         <= PC_FUSE;
            opc_q      <= OPC_FUSE;
            byte_q     <= 1'b0;
            addr_q     <= '0;
            wd_q       <= '0;
            tclk       <= 1'b1;
            done       <= 1'b0;
            fail       <= 1'b0;
            fuse_blown <= 1'b0;
            rdata      <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (op_start) begin
                        opc_q      <= opc_e'(op_code);
                        byte_q     <= op_byte;
                        addr_q     <= op_addr;
                        wd_q       <= op_wdata;
                        fail       <= 1'b0;
                        fuse_blown <= 1'b0;
                        case (opc_e'(op_code))
                            OPC_FUSE: begin
                                pc <= PC_FUSE;
                                st <= ST_STEP;
                            end
                            OPC_READ, OPC_WRITE: begin
                                pc <= PC_HALT;
                                st <= ST_STEP;
                            end
                            default: done <= 1'b1;
                        endcase
                    end
                end
                ST_STEP: begin
                    if (is_scan) begin
                        st <= ST_WAIT;
                    end else begin
                        tclk <= (step.kind == STK_TCLK_HI);
                        if (step.last) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            pc <= pc_next;
                        end
                    end
                end
                ST_WAIT: begin
                    if (fin) begin
                        st <= ST_STEP;
                        pc <= pc_next;
                        case (step.chk)
                            CHK_FUSE: begin
                                if (fin_data == FUSE_GONE) begin
                                    fuse_blown <= 1'b1;
                                    done       <= 1'b1;
                                    st         <= ST_IDLE;
                                end else if (fuse_last) begin
                                    done <= 1'b1;
                                    st   <= ST_IDLE;
                                end else begin
                                    pc <= PC_FUSE;
                                end
                            end
                            CHK_FETCH: begin
                                if (fin_data[FETCH_BIT]) begin
                                    pc <= PC_FROZEN;
                                end else if (fetch_last) begin
                                    fail <= 1'b1;
                                    done <= 1'b1;
                                    st   <= ST_IDLE;
                                end else begin
                                    pc <= PC_PULSE;
                                end
                            end
                            CHK_GRAB: begin
                                rdata <= byte_q ? {8'h00, fin_data[7:0]} : fin_data;
                            end
                            default: ;
                        endcase
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);

endmodule

// File: rtl/dbg_mem_seq_chk.sv
// Protocol checker for the debug memory access sequencer, bound to the top.
// Assumes the engine acknowledges only pending requests and the host never
// pulses op_start in the cycle done is high.
module dbg_mem_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_start,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          fuse_blown,
    input logic          tclk,
    input logic          scan_req,
    input logic          scan_kind,
    input logic [DW-1:0] scan_val,
    input logic          scan_ack
);

    // R12: a pending request keeps its type and value until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req && !scan_ack |=> scan_req && $stable(scan_kind) && $stable(scan_val));

    // R1: no scan is requested while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scan_req);

    // R9: done is only raised once the sequencer has gone idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: a poll timeout is reported together with done
    p_fail_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);

    // R8: an operation that did not abort leaves TCLK high
    p_tclk_high_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fail |-> tclk);

    // R11: busy only rises after a start pulse
    p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_start));

    // R10: the two status flags never show together
    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail && fuse_blown));

endmodule

bind dbg_mem_seq dbg_mem_seq_chk #(.DW(16)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fuse_blown (fuse_blown),
    .tclk       (tclk),
    .scan_req   (scan_req),
    .scan_kind  (scan_kind),
    .scan_val   (scan_val),
    .scan_ack   (scan_ack)
);

// File: tb/dbg_mem_seq_tb.sv
module dbg_mem_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic        op_byte = 1'b0;
    logic [15:0] op_addr = '0;
    logic [15:0] op_wdata = '0;
    logic        busy, done, fail, fuse_blown, tclk;
    logic [15:0] rdata;
    logic        scan_req, scan_kind;
    logic [15:0] scan_val;
    logic        scan_ack = 1'b0;
    logic [15:0] scan_ret = '0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_mem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
        .op_byte(op_byte), .op_addr(op_addr), .op_wdata(op_wdata),
        .busy(busy), .done(done), .rdata(rdata), .fail(fail),
        .fuse_blown(fuse_blown), .tclk(tclk), .scan_req(scan_req),
        .scan_kind(scan_kind), .scan_val(scan_val), .scan_ack(scan_ack),
        .scan_ret(scan_ret)
    );

    // ---------------- shift engine / target model ----------------
    int          cfg_blown_at = 0;   // fuse attempt returning blown, 0 = never
    int          cfg_fetch_after = 0; // polls answered "not fetching"
    int          cfg_delay = 0;      // extra acknowledge latency
    logic [15:0] cfg_mem = '0;

    logic [17:0] log_q [0:255];
    int          log_n = 0;
    int          viol = 0;
    int          fuse_cnt = 0, poll_cnt = 0, wcnt = 0;
    logic [7:0]  last_ir = '0;
    logic [15:0] hold_v = '0;
    logic        hold_k = 1'b0;
    logic        prev_tclk = 1'b1;
    logic [15:0] resp_t;

    always @(posedge clk) begin
        prev_tclk <= tclk;
        if (op_start && !busy) begin
            fuse_cnt <= 0;
            poll_cnt <= 0;
            log_n    <= 0;
        end else if (rst_n && tclk != prev_tclk) begin
            if (log_n < 256) log_q[log_n] <= {2'b10, 15'd0, tclk};
            log_n <= log_n + 1;
        end
        if (scan_req && !scan_ack) begin
            if (wcnt == 0) begin
                hold_v <= scan_val;
                hold_k <= scan_kind;
            end else if (scan_val != hold_v || scan_kind != hold_k) begin
                viol <= viol + 1;
            end
            if (wcnt >= cfg_delay) begin
                resp_t = 16'h0000;
                if (!scan_kind) begin
                    last_ir <= scan_val[7:0];
                end else if (last_ir == 8'h14 && scan_val == 16'hAAAA) begin
                    resp_t = (fuse_cnt + 1 == cfg_blown_at) ? 16'h5555 : 16'h0000;
                    fuse_cnt <= fuse_cnt + 1;
                end else if (last_ir == 8'h14) begin
                    resp_t = (poll_cnt >= cfg_fetch_after) ? 16'h0080 : 16'h0200;
                    poll_cnt <= poll_cnt + 1;
                end else if (last_ir == 8'h85) begin
                    resp_t = cfg_mem;
                end
                scan_ack <= 1'b1;
                scan_ret <= resp_t;
                wcnt     <= 0;
                if (log_n < 256) log_q[log_n] <= {1'b0, scan_kind, scan_val};
                log_n <= log_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            scan_ack <= 1'b0;
            if (wcnt != 0 && !scan_req) viol <= viol + 1;
            wcnt <= 0;
        end
    end

    // ---------------- expected transcript ----------------
    logic [17:0] exp_q [0:255];
    int          exp_n;
    logic        mlev;
    int          checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic exp_clear();
        exp_n = 0;
        mlev  = 1'b1;
    endtask

    task automatic push_ir(input logic [7:0] c);
        exp_q[exp_n] = {2'b00, 8'h00, c};
        exp_n++;
    endtask

    task automatic push_dr(input logic [15:0] v);
        exp_q[exp_n] = {2'b01, v};
        exp_n++;
    endtask

    task automatic push_tclk(input logic l);
        if (l != mlev) begin
            exp_q[exp_n] = {2'b10, 15'd0, l};
            exp_n++;
            mlev = l;
        end
    endtask

    task automatic exp_fuse(input int blown_at);
        for (int a = 1; a <= 3; a++) begin
            push_ir(8'h14);
            push_dr(16'hAAAA);
            if (a == blown_at) break;
        end
    endtask

    task automatic exp_halt(input int fa, output bit ok);
        ok = 1'b0;
        push_ir(8'h14);
        for (int i = 0; i < 50; i++) begin
            push_dr(16'h0000);
            if (i == fa) begin
                ok = 1'b1;
                break;
            end
            if (i == 49) break;
            push_tclk(1'b0);
            push_tclk(1'b1);
        end
        if (ok) begin
            push_ir(8'h13); push_dr(16'h2401);
            push_ir(8'h41); push_dr(16'h3FFF);
            push_tclk(1'b1); push_tclk(1'b0);
            push_ir(8'h13); push_dr(16'h2409);
            push_tclk(1'b1);
        end
    endtask

    task automatic exp_access(input bit wr, input bit byt, input logic [15:0] a, input logic [15:0] wd);
        push_tclk(1'b0);
        push_ir(8'h13);
        push_dr(wr ? (byt ? 16'h2418 : 16'h2408) : (byt ? 16'h2419 : 16'h2409));
        push_ir(8'h83);
        push_dr(a);
        push_ir(8'h85);
        if (wr) begin
            push_dr(wd);
            push_tclk(1'b1);
        end else begin
            push_tclk(1'b1); push_tclk(1'b0);
            push_dr(16'h0000);
            push_tclk(1'b1);
        end
    endtask

    task automatic exp_release();
        push_tclk(1'b0);
        push_ir(8'h13);
        push_dr(16'h2401);
        push_ir(8'h84);
        push_tclk(1'b1);
    endtask

    task automatic cmp_log(input string tag);
        int bad = -1;
        chk(log_n == exp_n, {tag, " transcript length"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < 256; i++) begin
            if (bad < 0 && log_q[i] !== exp_q[i]) bad = i;
        end
        if (bad >= 0) chk(1'b0, {tag, " transcript entry"}, {14'd0, log_q[bad]}, {14'd0, exp_q[bad]});
        else          chk(1'b1, tag, 0, 0);
    endtask

    // start one operation and wait for its end; counts done pulses
    task automatic run_op(input logic [1:0] op, input bit byt, input logic [15:0] a,
                          input logic [15:0] wd, input int extra_at,
                          output int dn, output bit fail_early);
        @(negedge clk);
        op_start = 1'b1; op_code = op; op_byte = byt; op_addr = a; op_wdata = wd;
        @(negedge clk);
        op_start = 1'b0;
        dn = 0;
        fail_early = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (i == 1) fail_early = fail;
            if (extra_at > 0 && i == extra_at) begin
                op_start = 1'b1; op_code = 2'd2; op_addr = 16'hFFFF; op_wdata = 16'hDEAD;
            end else begin
                op_start = 1'b0;
            end
            if (done) dn++;
            if (!busy && dn > 0) break;
            @(negedge clk);
        end
        op_start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (done) dn++;
        end
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        byt;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [15:0] mem;
        logic [7:0]  fetch_after;
        logic [3:0]  delay;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd1, 1'b0, 16'h0200, 16'h0000, 16'hBEEF, 8'd0, 4'd0, 16'hBEEF},
        '{2'd1, 1'b1, 16'h0201, 16'h0000, 16'hA55A, 8'd2, 4'd0, 16'h005A},
        '{2'd2, 1'b0, 16'h0300, 16'h1234, 16'h0000, 8'd1, 4'd0, 16'h005A},
        '{2'd2, 1'b1, 16'h0301, 16'h00C3, 16'h0000, 8'd0, 4'd2, 16'h005A},
        '{2'd1, 1'b0, 16'hFFFE, 16'h0000, 16'h0F0F, 8'd3, 4'd3, 16'h0F0F},
        '{2'd1, 1'b1, 16'h1000, 16'h0000, 16'hFF80, 8'd49, 4'd0, 16'h0080}
    };

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        int  dn;
        bit  fe, ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !scan_req, "R1 idle after reset", {busy, done, scan_req}, 0);
        chk(tclk == 1'b1, "R1 tclk high after reset", tclk, 1);
        chk(!fail && !fuse_blown && rdata == 16'h0, "R1 status and rdata clear", {fail, fuse_blown, rdata}, 0);

        // table of read/write operations (R4 R5 R6 R7 R8 R12)
        for (int v = 0; v < NV; v++) begin
            cfg_fetch_after = VECS[v].fetch_after;
            cfg_mem         = VECS[v].mem;
            cfg_delay       = VECS[v].delay;
            run_op(VECS[v].op, VECS[v].byt, VECS[v].addr, VECS[v].wd, 0, dn, fe);
            exp_clear();
            exp_halt(VECS[v].fetch_after, ok);
            exp_access(VECS[v].op == 2'd2, VECS[v].byt, VECS[v].addr, VECS[v].wd);
            exp_release();
            cmp_log(VECS[v].op == 2'd2 ? "R7 R4 R8 write sequence" : "R5 R4 R8 read sequence");
            chk(dn == 1, "R9 single done", dn, 1);
            chk(!fail, "R3 no fail on successful poll", fail, 0);
            if (VECS[v].op == 2'd1)
                chk(rdata == VECS[v].exp_rd, VECS[v].byt ? "R6 byte read masked" : "R5 word read data",
                    rdata, VECS[v].exp_rd);
        end
        cfg_delay = 0;
        chk(viol == 0, "R12 request held until ack", viol, 0);

        // R2 fuse: never blown, blown on attempt 2, blown on attempt 1
        for (int b = 0; b < 3; b++) begin
            cfg_blown_at = (b == 0) ? 0 : ((b == 1) ? 2 : 1);
            run_op(2'd0, 1'b0, 16'h0, 16'h0, 0, dn, fe);
            exp_clear();
            exp_fuse(cfg_blown_at);
            cmp_log("R2 fuse check scans");
            chk(fuse_blown == (cfg_blown_at != 0), "R2 fuse result", fuse_blown, cfg_blown_at != 0);
            chk(dn == 1, "R9 single done on fuse check", dn, 1);
        end
        // R10 blown flag persists while idle, clears on next start
        repeat (4) @(negedge clk);
        chk(fuse_blown, "R10 blown held while idle", fuse_blown, 1);
        cfg_blown_at = 0;
        cfg_fetch_after = 0;
        cfg_mem = 16'h1357;
        run_op(2'd1, 1'b0, 16'h0400, 16'h0, 0, dn, fe);
        chk(!fuse_blown, "R10 blown cleared by next op", fuse_blown, 0);

        // R3 poll timeout aborts with fail
        cfg_fetch_after = 60;
        run_op(2'd1, 1'b0, 16'h0500, 16'h0, 0, dn, fe);
        exp_clear();
        exp_halt(60, ok);
        cmp_log("R3 timeout transcript");
        chk(fail, "R3 fail on timeout", fail, 1);
        chk(rdata == 16'h1357, "R3 rdata untouched after abort", rdata, 16'h1357);
        repeat (5) @(negedge clk);
        chk(fail && !busy && !scan_req, "R10 fail held while idle", {fail, busy, scan_req}, 3'b100);
        cfg_fetch_after = 0;
        cfg_mem = 16'h2468;
        run_op(2'd1, 1'b0, 16'h0600, 16'h0, 0, dn, fe);
        chk(!fe, "R10 fail cleared once next op starts", fe, 0);

        // R11 start while busy is ignored
        cfg_mem = 16'h7777;
        run_op(2'd1, 1'b0, 16'h0700, 16'h0, 6, dn, fe);
        exp_clear();
        exp_halt(0, ok);
        exp_access(1'b0, 1'b0, 16'h0700, 16'h0);
        exp_release();
        cmp_log("R11 busy start ignored");
        chk(rdata == 16'h7777 && dn == 1, "R11 result unchanged", {rdata, 8'(dn)}, {16'h7777, 8'd1});
        repeat (6) @(negedge clk);
        chk(!busy, "R11 no second operation", busy, 0);

        // R9 reserved op code completes at once with no scans
        run_op(2'd3, 1'b0, 16'h0, 16'h0, 0, dn, fe);
        chk(dn == 1 && log_n == 0, "R9 reserved op", {8'(dn), 8'(log_n)}, {8'd1, 8'd0});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule